// File: doc/BRIEF.md
# Eight-Function Shared-Adder ALU

A purely combinational arithmetic and logic unit with a configurable operand width. Two operands and a 3-bit function code go in. An n-bit result, a carry flag and a signed overflow flag come out. There are no registers. The outputs follow the inputs within the same cycle, so the block can sit inside any datapath stage.

The function code is wired straight into the datapath and is never decoded. The middle bit inverts the second operand on its way into the single ripple adder. The low bit is the adder's carry-in. Together these give four arithmetic operations from one adder: A+B, A+B+1, A-B-1 and A-B.

Four bitwise results are formed side by side. The two low code bits choose one of them. The top code bit chooses between the adder path and the bitwise path. For bitwise operations both flags are held at zero.

Top module: `alu_fn8`

## Requirements
- R1: Code 3'b000 gives R = (A + B) mod 2^n, and C is the carry out of bit n-1 of that sum.
- R2: Code 3'b001 gives R = (A + B + 1) mod 2^n, and C is the carry out of that sum.
- R3: Code 3'b010 gives R = (A + ~B) mod 2^n, which equals A - B - 1. C is the carry out of A + ~B, so C = 1 exactly when A > B.
- R4: Code 3'b011 gives R = (A - B) mod 2^n, formed as A + ~B + 1. C = 1 exactly when A >= B, so a borrow shows as C = 0.
- R5: Codes 3'b100, 3'b101, 3'b110 and 3'b111 give bitwise AND, OR, NOR and XOR of A and B, in that order.
- R6: For codes 3'b000 to 3'b011, V = 1 exactly when the two adder operands (A and the possibly inverted B) have the same sign bit and R has the opposite sign bit.
- R7: For codes 3'b100 to 3'b111, C = 0 and V = 0 for any operands.
- R8: The operand width is set by parameter N. Every operation above holds modulo 2^N at each width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| f | input | 3 | Function code |
| r | output | N | Result |
| c | output | 1 | Carry out of the adder's top bit (0 for bitwise codes) |
| v | output | 1 | Signed overflow (0 for bitwise codes) |

## Verification
The bench builds the unit with N = 4. At that width every pair of operands under every function code can be applied, 2048 combinations in all. This covers every carry and overflow boundary, including most-positive plus one, all-ones plus one, and subtraction with A below B. Expected results come from sums taken one bit wider than the operands. A few named corner cases are then checked on their own, so that each boundary can be identified by its requirement.

// File: rtl/alu_fn8.sv
module alu_fn8 #(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [2:0]   f,
  output logic [N-1:0] r,
  output logic         c,
  output logic         v
);

  logic [N-1:0] bx;
  logic [N-1:0] sum;
  logic [N:0]   cy;
  logic [N-1:0] lg;

  assign bx    = b ^ {N{f[1]}};
  assign cy[0] = f[0];

  for (genvar i = 0; i < N; i++) begin : g_rip
    assign sum[i]  = a[i] ^ bx[i] ^ cy[i];
    assign cy[i+1] = (a[i] & bx[i]) | (cy[i] & (a[i] ^ bx[i]));
  end

  always_comb begin
    case (f[1:0])
      2'b00:   lg = a & b;
      2'b01:   lg = a | b;
      2'b10:   lg = ~(a | b);
      default: lg = a ^ b;
    endcase
  end

  assign r = f[2] ? lg : sum;
  assign c = ~f[2] & cy[N];
  assign v = ~f[2] & (cy[N] ^ cy[N-1]);

endmodule

module alu_fn8_props #(
  parameter int N = 8
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic [2:0]   f,
  input logic [N-1:0] r,
  input logic         c,
  input logic         v
);

  logic [N:0]   wide_add;
  logic [N:0]   wide_sub;
  logic [N-1:0] opb;

  assign wide_add = {1'b0, a} + {1'b0, b};
  assign wide_sub = {1'b0, a} + {1'b0, ~b} + (N+1)'(1);
  assign opb      = f[1] ? ~b : b;

  always_comb begin
    if (f == 3'b000) begin
      assert_add_R1: assert ({c, r} == wide_add);
    end
    if (f == 3'b011) begin
      assert_sub_R4: assert (r == a - b && c == (a >= b));
    end
    if (f == 3'b100) begin
      assert_and_R5: assert (r == (a & b));
    end
    if (f == 3'b110) begin
      assert_nor_R5: assert (r == ~(a | b));
    end
    if (!f[2]) begin
      assert_no_overflow_R6: assert (v == ((a[N-1] == opb[N-1]) && (r[N-1] != a[N-1])));
    end
    if (f[2]) begin
      assert_flags_clear_R7: assert (!c && !v);
    end
  end

endmodule

bind alu_fn8 alu_fn8_props #(.N(N)) u_props (.*);

// File: tb/alu_fn8_bench.sv
`timescale 1ns/1ps
module alu_fn8_bench;
  localparam int N = 4;
  localparam int M = 1 << N;

  logic clk = 0;
  always #2 clk = ~clk;

  logic [N-1:0] a, b;
  logic [2:0]   f;
  logic [N-1:0] r;
  logic         c, v;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  alu_fn8 #(.N(N)) u_alu_fn8 (.a(a), .b(b), .f(f), .r(r), .c(c), .v(v));

  task automatic chk(input string req, input logic [N+1:0] act, input logic [N+1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d f=%0d actual=%0h expected=%0h", req, a, b, f, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] fc);
    case (fc)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(input logic [N-1:0] ai, input logic [N-1:0] bi, input logic [2:0] fi);
    @(posedge clk);
    a = ai; b = bi; f = fi;
    @(negedge clk);
  endtask

  task automatic sweep_one(input logic [2:0] fi, input int ai, input int bi);
    logic [N-1:0] ob, er;
    logic [N:0]   w;
    logic         ec, ev;
    apply(N'(ai), N'(bi), fi);
    ob = fi[1] ? ~N'(bi) : N'(bi);
    w  = {1'b0, N'(ai)} + {1'b0, ob} + (N+1)'(fi[0]);
    if (!fi[2]) begin
      er = w[N-1:0];
      ec = w[N];
      ev = (a[N-1] == ob[N-1]) && (er[N-1] != a[N-1]);
      chk(req_of(fi), {2'b00, r}, {2'b00, er});
      chk(req_of(fi), {{N{1'b0}}, c}, {{N{1'b0}}, ec});
      chk("R6", {{N{1'b0}}, v}, {{N{1'b0}}, ev});
    end else begin
      case (fi[1:0])
        2'b00:   er = a & b;
        2'b01:   er = a | b;
        2'b10:   er = ~(a | b);
        default: er = a ^ b;
      endcase
      chk("R5", {2'b00, r}, {2'b00, er});
      chk("R7", {N'(0), c, v}, '0);
    end
  endtask

  initial begin
    apply('0, '0, 3'b000);
    chk("R1", {c, v, r}, '0);

    apply(N'(M/2 - 1), N'(1), 3'b000);
    chk("R6", {c, v, r}, {1'b0, 1'b1, N'(M/2)});

    apply(N'(M - 1), N'(1), 3'b000);
    chk("R1", {c, v, r}, {1'b1, 1'b0, N'(0)});

    apply(N'(M - 1), N'(0), 3'b001);
    chk("R2", {c, r}, {2'b01, N'(0)});

    apply(N'(3), N'(5), 3'b011);
    chk("R4", {c, r}, {2'b00, N'(M - 2)});

    apply(N'(5), N'(5), 3'b011);
    chk("R4", {c, r}, {2'b01, N'(0)});

    apply(N'(5), N'(5), 3'b010);
    chk("R3", {c, r}, {2'b00, N'(M - 1)});

    apply(N'(M - 1), N'(M - 1), 3'b111);
    chk("R7", {c, v, r}, '0);

    for (int fi = 0; fi < 8; fi++)
      for (int ai = 0; ai < M; ai++)
        for (int bi = 0; bi < M; bi++)
          sweep_one(3'(fi), ai, bi);

    done = 1;
  end

  initial begin
    for (int k = 0; k < 100000 && !done; k++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule